// File: doc/BRIEF.md
# ADC Calibration Mode Sequencer

This block is the control state machine in the digital back end of a sigma-delta converter. Software writes a 3-bit mode code through a register interface. The sequencer then runs one calibration step: zero-scale or full-scale, against either the internal references (self) or a level applied by the system at the analog input (system). After the step it runs the follow-up conversion and drives the active-low data-ready flag. The datapath is told when to capture the offset or the gain coefficient, whether the internal references are in use, and whether the calibration span is bipolar. The modulator, the decimation filter and the coefficient arithmetic sit outside the block.

There are three states. `ST_NORMAL` is continuous conversion. `ST_CAL` is a running calibration step. `ST_CONV` is the conversion that follows a step.

The transitions are:
- `ST_NORMAL` to `ST_CAL` when a command is accepted.
- `ST_CAL` to `ST_CONV` at the end of the step.
- `ST_CONV` to `ST_CAL` when a new command is accepted during the conversion (restart).
- `ST_CONV` to `ST_NORMAL` when the conversion word is loaded.

Time is counted in pulses of the output-word tick. The rise of data-ready after a command is aligned to the modulator tick.

Top module: `adc_cal_sequencer`

## Requirements
- R1: After reset the outputs are in their idle state: `mode_rd` = 000, `drdy_n` = 1, both capture strobes 0, `cal_err` = 0, `cal_internal` = 0. No valid offset is held.
- R2: Only four write codes start a calibration: 110 (self zero-scale), 111 (self full-scale), 010 (system zero-scale) and 011 (system full-scale). An accepted code is read back on `mode_rd` in the cycle after the write. Any other code leaves `mode_rd` at 000 and changes nothing else.
- R3: A step ends on the third `owr_tick` that follows the write cycle; a tick in the write cycle itself is not counted. In the cycle after that tick, `mode_rd` reads 000 and exactly one capture strobe is high for one cycle. The strobe is `cap_offset` when bit 0 of the code is 0 and `cap_gain` when bit 0 is 1.
- R4: When a command is accepted, `drdy_n` goes high no later than the cycle after the first `mod_tick` that follows the write cycle. If `drdy_n` is already high, it stays high.
- R5: After a self step, `drdy_n` goes low in the cycle after the sixth counted `owr_tick` from the command (three for the step, three for the conversion).
- R6: After a system step, `drdy_n` goes low in the cycle after the fourth counted `owr_tick` from the command (three for the step, one for the conversion).
- R7: A full-scale code (111 or 011) written while no valid offset exists is refused. `mode_rd` stays 000, the sticky `cal_err` goes to 1, and `drdy_n` is not changed. The offset becomes valid when any zero-scale step completes and stays valid until reset.
- R8: A mode write while `mode_rd` is not 000 is ignored. A calibration code written during the follow-up conversion is accepted and restarts the sequence with the new step.
- R9: `cal_internal` is 1 during a self step and 0 during a system step. `cal_span_bip` takes the value of `bipolar` at the accepted write and holds it for the whole step. In this span flag, 1 means midscale to positive full scale and 0 means the two endpoints.
- R10: In normal conversion, `drdy_n` goes low in the cycle after a `conv_done` pulse and high in the cycle after an `owr_tick`. If both arrive in the same cycle, `drdy_n` goes low. `conv_done` has no effect during a step or its follow-up conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_tick | input | 1 | One-cycle pulse per modulator cycle |
| owr_tick | input | 1 | One-cycle pulse per output-word period |
| mode_wr | input | 1 | Mode-register write strobe |
| mode_wdata | input | 3 | Mode code being written |
| bipolar | input | 1 | 1 selects bipolar coding, 0 unipolar |
| conv_done | input | 1 | Normal-mode conversion word loaded |
| mode_rd | output | 3 | Read-back mode field |
| cap_offset | output | 1 | Strobe: capture offset coefficient |
| cap_gain | output | 1 | Strobe: capture gain coefficient |
| cal_internal | output | 1 | Step uses internal references |
| cal_span_bip | output | 1 | Calibration span is midscale to positive full scale |
| cal_err | output | 1 | Sticky: full-scale command refused |
| drdy_n | output | 1 | Active-low data-ready |

## Verification
Every result appears one register stage after the input that causes it:
- `mode_rd` and `cal_err` change in the cycle after the write.
- The capture strobes and the 000 read-back appear in the cycle after the third counted word tick.
- `drdy_n` rises in the cycle after the first modulator tick that follows the write.
- `drdy_n` falls in the cycle after the sixth (self) or fourth (system) counted word tick.

The bench drives each input for exactly one clock from a falling edge and samples at the next falling edge. Each sample therefore sees the output one rising edge after its cause. Checks taken before the final tick confirm that nothing changes early.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_NORMAL  = 3'b000;
    localparam logic [MODE_W-1:0] MODE_ZS_SELF = 3'b110;
    localparam logic [MODE_W-1:0] MODE_FS_SELF = 3'b111;
    localparam logic [MODE_W-1:0] MODE_ZS_SYS  = 3'b010;
    localparam logic [MODE_W-1:0] MODE_FS_SYS  = 3'b011;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_CAL    = 2'd1,
        ST_CONV   = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic is_cal;
        logic is_fs;
        logic is_self;
    } cmd_info_t;

endpackage

// File: rtl/adc_cal_decode.sv
module adc_cal_decode
    import adc_cal_pkg::*;
(
    input  logic [MODE_W-1:0] code,
    output cmd_info_t         info
);
    always_comb begin
        info = '0;
        case (code)
            MODE_ZS_SELF: info = '{is_cal: 1'b1, is_fs: 1'b0, is_self: 1'b1};
            MODE_FS_SELF: info = '{is_cal: 1'b1, is_fs: 1'b1, is_self: 1'b1};
            MODE_ZS_SYS:  info = '{is_cal: 1'b1, is_fs: 1'b0, is_self: 1'b0};
            MODE_FS_SYS:  info = '{is_cal: 1'b1, is_fs: 1'b1, is_self: 1'b0};
            default:      info = '0;
        endcase
    end
endmodule

// File: rtl/adc_cal_period_cnt.sv
module adc_cal_period_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] last_idx,
    output logic             at_last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    assign at_last = (cnt_q == last_idx);
endmodule

// File: rtl/adc_cal_drdy.sv
module adc_cal_drdy (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic mod_tick,
    input  logic word_load,
    input  logic norm_load,
    input  logic norm_clear,
    output logic drdy_n
);
    logic pend_q;
    logic drdy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            drdy_q <= 1'b1;
        end else if (arm) begin
            pend_q <= 1'b1;
        end else if (word_load) begin
            pend_q <= 1'b0;
            drdy_q <= 1'b0;
        end else if (pend_q && mod_tick) begin
            pend_q <= 1'b0;
            drdy_q <= 1'b1;
        end else if (norm_load) begin
            drdy_q <= 1'b0;
        end else if (norm_clear) begin
            drdy_q <= 1'b1;
        end
    end

    assign drdy_n = drdy_q;
endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
    import adc_cal_pkg::*;
#(
    parameter int CAL_PERIODS       = 3,
    parameter int SELF_CONV_PERIODS = 3,
    parameter int SYS_CONV_PERIODS  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_tick,
    input  logic              owr_tick,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              bipolar,
    input  logic              conv_done,
    output logic [MODE_W-1:0] mode_rd,
    output logic              cap_offset,
    output logic              cap_gain,
    output logic              cal_internal,
    output logic              cal_span_bip,
    output logic              cal_err,
    output logic              drdy_n
);
    localparam int MAX_CONV = (SELF_CONV_PERIODS > SYS_CONV_PERIODS) ?
                              SELF_CONV_PERIODS : SYS_CONV_PERIODS;
    localparam int MAX_P    = (CAL_PERIODS > MAX_CONV) ? CAL_PERIODS : MAX_CONV;
    localparam int CNT_W    = (MAX_P > 1) ? $clog2(MAX_P) : 1;
    localparam logic [CNT_W-1:0] CAL_LAST  = CNT_W'(CAL_PERIODS - 1);
    localparam logic [CNT_W-1:0] SELF_LAST = CNT_W'(SELF_CONV_PERIODS - 1);
    localparam logic [CNT_W-1:0] SYS_LAST  = CNT_W'(SYS_CONV_PERIODS - 1);

    seq_state_t        state_q, state_d;
    logic [MODE_W-1:0] mode_q;
    logic              is_fs_q, is_self_q, span_q;
    logic              off_valid_q, err_q;
    logic              cap_off_q, cap_gain_q;

    cmd_info_t         wr_info;
    logic              can_write, refuse, accept;
    logic              step_end, conv_end, at_last;
    logic [CNT_W-1:0]  last_idx;

    adc_cal_decode u_decode (
        .code (mode_wdata),
        .info (wr_info)
    );

    // Command gate: writes are seen only outside a running step.
    assign can_write = mode_wr && wr_info.is_cal && (state_q != ST_CAL);
    assign refuse    = can_write && wr_info.is_fs && !off_valid_q;
    assign accept    = can_write && !refuse;

    always_comb begin
        unique case (state_q)
            ST_CAL:  last_idx = CAL_LAST;
            ST_CONV: last_idx = is_self_q ? SELF_LAST : SYS_LAST;
            default: last_idx = CAL_LAST;
        endcase
    end

    adc_cal_period_cnt #(.CNT_W(CNT_W)) u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept || step_end),
        .inc      (owr_tick && (state_q != ST_NORMAL)),
        .last_idx (last_idx),
        .at_last  (at_last)
    );

    assign step_end = (state_q == ST_CAL)  && owr_tick && at_last;
    assign conv_end = (state_q == ST_CONV) && owr_tick && at_last && !accept;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: if (accept) state_d = ST_CAL;
            ST_CAL:    if (step_end) state_d = ST_CONV;
            ST_CONV: begin
                if (accept)        state_d = ST_CAL;
                else if (conv_end) state_d = ST_NORMAL;
            end
            default:   state_d = ST_NORMAL;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    // Registered outputs and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= MODE_NORMAL;
            is_fs_q     <= 1'b0;
            is_self_q   <= 1'b0;
            span_q      <= 1'b0;
            off_valid_q <= 1'b0;
            err_q       <= 1'b0;
            cap_off_q   <= 1'b0;
            cap_gain_q  <= 1'b0;
        end else begin
            cap_off_q  <= step_end && !is_fs_q;
            cap_gain_q <= step_end && is_fs_q;
            if (accept) begin
                mode_q    <= mode_wdata;
                is_fs_q   <= wr_info.is_fs;
                is_self_q <= wr_info.is_self;
                span_q    <= bipolar;
            end else if (step_end) begin
                mode_q <= MODE_NORMAL;
            end
            if (step_end && !is_fs_q) off_valid_q <= 1'b1;
            if (refuse)               err_q       <= 1'b1;
        end
    end

    adc_cal_drdy u_drdy (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (accept),
        .mod_tick   (mod_tick),
        .word_load  (conv_end),
        .norm_load  (conv_done && (state_q == ST_NORMAL)),
        .norm_clear (owr_tick && (state_q == ST_NORMAL)),
        .drdy_n     (drdy_n)
    );

    assign mode_rd      = mode_q;
    assign cap_offset   = cap_off_q;
    assign cap_gain     = cap_gain_q;
    assign cal_internal = (state_q == ST_CAL) && is_self_q;
    assign cal_span_bip = span_q;
    assign cal_err      = err_q;
endmodule

// File: rtl/adc_cal_sequencer_chk.sv
module adc_cal_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_rd,
    input logic       cap_offset,
    input logic       cap_gain,
    input logic       cal_span_bip,
    input logic       cal_err,
    input logic       off_valid
);
    assert_legal_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rd inside {3'b000, 3'b110, 3'b111, 3'b010, 3'b011});

    assert_cap_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_offset && cap_gain));

    assert_cap_at_step_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_offset || cap_gain) |-> (mode_rd == 3'b000 && $past(mode_rd) != 3'b000));

    assert_gain_from_fs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_gain |-> $past(mode_rd[0]));

    assert_offset_from_zs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_offset |-> !$past(mode_rd[0]));

    assert_fs_needs_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == 3'b111 || mode_rd == 3'b011) |-> off_valid);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cal_err |=> cal_err);

    assert_offset_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        off_valid |=> off_valid);

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd != 3'b000 && $past(mode_rd) != 3'b000) |-> mode_rd == $past(mode_rd));

    assert_span_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd != 3'b000 && $past(mode_rd) != 3'b000) |-> $stable(cal_span_bip));
endmodule

bind adc_cal_sequencer adc_cal_sequencer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_rd      (mode_rd),
    .cap_offset   (cap_offset),
    .cap_gain     (cap_gain),
    .cal_span_bip (cal_span_bip),
    .cal_err      (cal_err),
    .off_valid    (off_valid_q)
);

// File: tb/adc_cal_sequencer_tb.sv
module adc_cal_sequencer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mod_tick = 1'b0, owr_tick = 1'b0, mode_wr = 1'b0;
    logic [2:0] mode_wdata = 3'b000;
    logic       bipolar = 1'b0, conv_done = 1'b0;
    logic [2:0] mode_rd;
    logic       cap_offset, cap_gain, cal_internal, cal_span_bip, cal_err, drdy_n;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    adc_cal_sequencer u_dut (
        .clk (clk), .rst_n (rst_n), .mod_tick (mod_tick), .owr_tick (owr_tick),
        .mode_wr (mode_wr), .mode_wdata (mode_wdata), .bipolar (bipolar),
        .conv_done (conv_done), .mode_rd (mode_rd), .cap_offset (cap_offset),
        .cap_gain (cap_gain), .cal_internal (cal_internal),
        .cal_span_bip (cal_span_bip), .cal_err (cal_err), .drdy_n (drdy_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock of stimulus, driven and released on falling edges.
    task automatic cyc(input logic wr, input logic [2:0] code, input logic owr,
                       input logic mt, input logic cd);
        mode_wr = wr; mode_wdata = code; owr_tick = owr; mod_tick = mt; conv_done = cd;
        @(negedge clk);
        mode_wr = 1'b0; owr_tick = 1'b0; mod_tick = 1'b0; conv_done = 1'b0;
    endtask

    task automatic write(input logic [2:0] code); cyc(1'b1, code, 1'b0, 1'b0, 1'b0); endtask
    task automatic owr();  cyc(1'b0, 3'b000, 1'b1, 1'b0, 1'b0); endtask
    task automatic mtick(); cyc(1'b0, 3'b000, 1'b0, 1'b1, 1'b0); endtask
    task automatic idle(); cyc(1'b0, 3'b000, 1'b0, 1'b0, 1'b0); endtask

    task automatic t_reset();
        chk("R1 mode", mode_rd, 3'b000);
        chk("R1 drdy_n", drdy_n, 1'b1);
        chk("R1 caps", {cap_offset, cap_gain}, 2'b00);
        chk("R1 err", cal_err, 1'b0);
        chk("R1 internal", cal_internal, 1'b0);
    endtask

    task automatic t_normal();
        cyc(1'b0, 3'b000, 1'b0, 1'b0, 1'b1);
        chk("R10 conv_done lowers", drdy_n, 1'b0);
        owr();
        chk("R10 owr raises", drdy_n, 1'b1);
        cyc(1'b0, 3'b000, 1'b1, 1'b0, 1'b1);
        chk("R10 both -> low", drdy_n, 1'b0);
    endtask

    task automatic t_refuse();
        write(3'b111);
        chk("R7 refused mode", mode_rd, 3'b000);
        chk("R7 err set", cal_err, 1'b1);
        chk("R7 drdy unchanged", drdy_n, 1'b0);
        mtick();
        chk("R7 drdy still unchanged", drdy_n, 1'b0);
    endtask

    task automatic t_bad_code();
        write(3'b101);
        chk("R2 other code ignored", mode_rd, 3'b000);
        mtick();
        chk("R2 other code drdy", drdy_n, 1'b0);
    endtask

    task automatic t_self_zs();
        cyc(1'b1, 3'b110, 1'b1, 1'b0, 1'b0);   // tick in write cycle not counted
        chk("R2 mode 110", mode_rd, 3'b110);
        chk("R9 internal self", cal_internal, 1'b1);
        chk("R4 not before mod tick", drdy_n, 1'b0);
        mtick();
        chk("R4 drdy high", drdy_n, 1'b1);
        owr(); owr();
        chk("R3 step still running", mode_rd, 3'b110);
        chk("R3 no early strobe", cap_offset, 1'b0);
        owr();
        chk("R3 mode cleared", mode_rd, 3'b000);
        chk("R3 offset strobe", {cap_offset, cap_gain}, 2'b10);
        cyc(1'b0, 3'b000, 1'b0, 1'b0, 1'b1);
        chk("R3 strobe one cycle", cap_offset, 1'b0);
        chk("R10 conv_done ignored in cal", drdy_n, 1'b1);
        owr(); owr();
        chk("R5 not before 6th", drdy_n, 1'b1);
        owr();
        chk("R5 drdy low after 6", drdy_n, 1'b0);
    endtask

    task automatic t_sys_zs();
        bipolar = 1'b1;
        write(3'b010);
        chk("R2 mode 010", mode_rd, 3'b010);
        chk("R9 internal sys", cal_internal, 1'b0);
        chk("R9 span captured", cal_span_bip, 1'b1);
        bipolar = 1'b0;
        write(3'b011);
        chk("R8 write in step ignored", mode_rd, 3'b010);
        chk("R9 span held", cal_span_bip, 1'b1);
        mtick();
        chk("R4 drdy high sys", drdy_n, 1'b1);
        owr(); owr(); owr();
        chk("R3 sys zs strobe", {cap_offset, cap_gain}, 2'b10);
        chk("R6 not before 4th", drdy_n, 1'b1);
        owr();
        chk("R6 drdy low after 4", drdy_n, 1'b0);
    endtask

    task automatic t_sys_fs();
        write(3'b011);
        chk("R7 fs accepted after zs", mode_rd, 3'b011);
        chk("R9 span unipolar", cal_span_bip, 1'b0);
        mtick();
        owr(); owr(); owr();
        chk("R3 gain strobe only", {cap_offset, cap_gain}, 2'b01);
        owr();
        chk("R6 sys fs drdy", drdy_n, 1'b0);
    endtask

    task automatic t_restart();
        write(3'b111);
        chk("R2 mode 111", mode_rd, 3'b111);
        mtick();
        owr(); owr(); owr();
        chk("R3 self fs gain", {cap_offset, cap_gain}, 2'b01);
        owr();
        write(3'b110);
        chk("R8 accepted in conversion", mode_rd, 3'b110);
        chk("R8 drdy still high", drdy_n, 1'b1);
        owr(); owr(); owr();
        chk("R8 restarted step ends", {cap_offset, cap_gain}, 2'b10);
        owr(); owr();
        chk("R5 restart not early", drdy_n, 1'b1);
        owr();
        chk("R5 restart drdy low", drdy_n, 1'b0);
        owr();
        chk("R10 normal resumes", drdy_n, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_refuse();
        t_bad_code();
        t_self_zs();
        t_sys_zs();
        t_sys_fs();
        t_restart();
        idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule